// File: doc/BRIEF.md
# Synch-Timed Fractional Baud Generator

This block sets the bit rate of a single-wire serial link by timing a synchronization character. The rate cannot be programmed directly. After an arm request, the block waits for the falling edge of the start bit. It then counts system clocks until the fourth falling edge after that one, which is the start of the last low bit of a 0x55 pattern sent LSB first behind a start bit. That span covers exactly eight bit periods. The count, shifted right by three, gives the bit period in clocks. The same value also reads as the length of one sixteenth of a bit, held as an integer part plus a 4-bit fraction.

From the stored value, a fractional divider emits a one-clock oversampling tick sixteen times per bit. A 4-bit phase accumulator adds the fraction on every tick. When the accumulator carries, the next interval is stretched by one clock, so the rounding error never accumulates beyond one clock. The receiver and the transmitter both use the tick. The rate stays in force until the next arm request. A measured period that is too short, or a measurement that runs too long, raises an error flag and leaves the rate invalid.

Top module: `autobaud_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `tick_o`, `baud_valid_o` and `synch_err_o` are all 0.
- R2: An `arm_i` pulse clears `baud_valid_o` and `synch_err_o` by the next cycle and starts a new measurement.
- R3: After arming, a 0x55 character on `line_i` (idle high, start bit low, then data LSB first, each bit P clocks) sets `baud_valid_o` to 1 with bit period P. P is taken as the clocks from the start-bit falling edge to the fifth falling edge, divided by 8.
- R4: While valid, ticks are one clock wide. Each interval between ticks is floor(P/16) or floor(P/16)+1 clocks. Any 16 consecutive intervals add up to exactly P clocks.
- R5: No tick is produced while `baud_valid_o` is 0.
- R6: A measured bit period below MIN_BIT_CLKS (default 32) sets `synch_err_o`, and `baud_valid_o` stays 0.
- R7: If eight bit periods have not been seen within TIMEOUT_CLKS (default 4096) clocks of the start edge, `synch_err_o` is set and `baud_valid_o` stays 0.
- R8: Once valid, line activity without a new arm changes neither `baud_valid_o` nor the tick spacing.
- R9: Line activity after reset but before any arm does not set `baud_valid_o` or `synch_err_o`.
- R10: A new arm followed by a synch character at a different rate replaces the stored rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line level, already synchronized, idle high |
| arm_i | input | 1 | One-cycle request to measure the next synch character |
| tick_o | output | 1 | Oversampling tick, 16 per bit period |
| baud_valid_o | output | 1 | A rate has been measured and is in force |
| synch_err_o | output | 1 | The last measurement was too fast or timed out |

## Verification
A wrong measured count shows up at the ports within the first 16 ticks after valid rises: the sum of the intervals differs from the bit period driven by the bench. A fractional accumulator that drops or doubles its carry appears within one window of 16 ticks as an interval outside the two permitted lengths, or as a wrong window sum. State machine faults show up within one character time. A missed arm leaves valid high, and a missed timeout or lower limit leaves the error flag low.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEAS
  } meas_state_e;

  // falling edges counted after the start edge to cover eight bit periods
  localparam int unsigned SPAN_EDGES = 4;
  localparam int unsigned SPAN_SHIFT = 3;
  localparam int unsigned FRAC_W     = 4;
endpackage

// File: rtl/synch_timer.sv
module synch_timer
  import autobaud_pkg::*;
#(
  parameter int unsigned MIN_BIT_CLKS = 32,
  parameter int unsigned TIMEOUT_CLKS = 4096,
  parameter int unsigned CNT_W        = $clog2(TIMEOUT_CLKS + 1),
  parameter int unsigned PER_W        = CNT_W - SPAN_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             arm_i,
  output logic [PER_W-1:0] period_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LIMIT_C   = CNT_W'(TIMEOUT_CLKS - 1);
  localparam logic [CNT_W-1:0] MIN_TOT_C = CNT_W'(MIN_BIT_CLKS * 8);
  localparam logic [2:0]       LAST_EDGE = 3'(SPAN_EDGES - 1);

  meas_state_e      state_q;
  logic             line_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       edges_q;
  logic             fall;
  logic [CNT_W-1:0] total;

  assign fall  = line_q & ~line_i;
  assign total = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      line_q   <= 1'b1;
      cnt_q    <= '0;
      edges_q  <= '0;
      period_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      line_q <= line_i;
      if (arm_i) begin
        state_q <= ST_WAIT;
        cnt_q   <= '0;
        edges_q <= '0;
        valid_o <= 1'b0;
        err_o   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_WAIT: begin
            if (fall) begin
              state_q <= ST_MEAS;
              cnt_q   <= '0;
              edges_q <= '0;
            end
          end
          ST_MEAS: begin
            cnt_q <= total;
            if (fall) edges_q <= edges_q + 3'd1;
            if (fall && edges_q == LAST_EDGE) begin
              state_q <= ST_IDLE;
              if (total < MIN_TOT_C) begin
                err_o <= 1'b1;
              end else begin
                valid_o  <= 1'b1;
                period_o <= total[CNT_W-1:SPAN_SHIFT];
              end
            end else if (cnt_q == LIMIT_C) begin
              state_q <= ST_IDLE;
              err_o   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frac_divider.sv
module frac_divider
  import autobaud_pkg::*;
#(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  localparam int unsigned INT_W = PER_W - FRAC_W;

  logic [INT_W-1:0]  int_part;
  logic [FRAC_W-1:0] frac_part;
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [INT_W:0]    lim;
  logic [FRAC_W:0]   acc_sum;

  assign int_part  = period_i[PER_W-1:FRAC_W];
  assign frac_part = period_i[FRAC_W-1:0];
  assign lim       = {1'b0, int_part} - (INT_W+1)'(1) + (INT_W+1)'(extra_q);
  assign acc_sum   = {1'b0, acc_q} + {1'b0, frac_part};

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
      tick_o  <= 1'b0;
    end else if ({1'b0, cnt_q} == lim) begin
      tick_o  <= 1'b1;
      cnt_q   <= '0;
      acc_q   <= acc_sum[FRAC_W-1:0];
      extra_q <= acc_sum[FRAC_W];
    end else begin
      tick_o <= 1'b0;
      cnt_q  <= cnt_q + INT_W'(1);
    end
  end
endmodule

// File: rtl/autobaud_gen.sv
module autobaud_gen
  import autobaud_pkg::*;
#(
  parameter int unsigned MIN_BIT_CLKS = 32,
  parameter int unsigned TIMEOUT_CLKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic arm_i,
  output logic tick_o,
  output logic baud_valid_o,
  output logic synch_err_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam int unsigned PER_W = CNT_W - SPAN_SHIFT;

  logic [PER_W-1:0] period;
  logic             run;

  synch_timer #(
    .MIN_BIT_CLKS(MIN_BIT_CLKS),
    .TIMEOUT_CLKS(TIMEOUT_CLKS),
    .CNT_W       (CNT_W),
    .PER_W       (PER_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .arm_i   (arm_i),
    .period_o(period),
    .valid_o (baud_valid_o),
    .err_o   (synch_err_o)
  );

  // stop ticking in the same edge that an arm request withdraws the rate
  assign run = baud_valid_o & ~arm_i;

  frac_divider #(
    .PER_W(PER_W)
  ) div_i (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .period_i(period),
    .tick_o  (tick_o)
  );
endmodule

// File: rtl/autobaud_gen_chk.sv
module autobaud_gen_chk (
  input logic clk,
  input logic rst,
  input logic arm_i,
  input logic tick_o,
  input logic baud_valid_o,
  input logic synch_err_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!tick_o && !baud_valid_o && !synch_err_o));

  p_arm_clears_r2: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!baud_valid_o && !synch_err_o));

  p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  p_tick_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> baud_valid_o);

  p_err_excl_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !(baud_valid_o && synch_err_o));

  p_rate_held_r8: assert property (@(posedge clk) disable iff (rst)
    (baud_valid_o && !arm_i) |=> baud_valid_o);
endmodule

bind autobaud_gen autobaud_gen_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .arm_i       (arm_i),
  .tick_o      (tick_o),
  .baud_valid_o(baud_valid_o),
  .synch_err_o (synch_err_o)
);

// File: tb/autobaud_gen_tb_top.sv
`timescale 1ns/1ps
module autobaud_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_i = 1'b1;
  logic arm_i = 1'b0;
  logic tick_o, baud_valid_o, synch_err_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  autobaud_gen dut_i (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line_i),
    .arm_i       (arm_i),
    .tick_o      (tick_o),
    .baud_valid_o(baud_valid_o),
    .synch_err_o (synch_err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic arm_pulse();
    @(posedge clk); #1 arm_i = 1'b1;
    @(posedge clk); #1 arm_i = 1'b0;
  endtask

  // start bit then 0x55 LSB first then stop, each bit p clocks
  task automatic send_synch(input int p);
    for (int i = 0; i < 10; i++) begin
      line_i = (i % 2 == 1);
      repeat (p) @(posedge clk);
      #1;
    end
    line_i = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick_o) n++;
    end
  endtask

  task automatic check_ticks(input int p, input string req);
    int gap, sum, lo;
    lo = p / 16;
    gap = 0;
    while (!tick_o && gap < 200) begin @(negedge clk); gap++; end
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick_o && gap < 200);
      sum += gap;
      if (gap != lo && gap != lo + 1)
        check(1'b0, req, "tick interval", gap, lo);
    end
    check(sum == p, req, "sum of 16 tick intervals", sum, p);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!tick_o && !baud_valid_o && !synch_err_o, "R1", "outputs in reset",
          {tick_o, baud_valid_o, synch_err_o}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!tick_o && !baud_valid_o && !synch_err_o, "R1", "outputs after reset",
          {tick_o, baud_valid_o, synch_err_o}, 0);
  endtask

  task automatic t_unarmed();
    int n;
    send_synch(40);
    @(negedge clk);
    check(!baud_valid_o && !synch_err_o, "R9", "flags without arm",
          {baud_valid_o, synch_err_o}, 0);
    count_ticks(100, n);
    check(n == 0, "R5", "ticks while invalid", n, 0);
  endtask

  task automatic t_measure(input int p, input string req);
    arm_pulse();
    send_synch(p);
    @(negedge clk);
    check(baud_valid_o == 1'b1, "R3", "valid after synch", baud_valid_o, 1);
    check(synch_err_o == 1'b0, "R3", "no error after synch", synch_err_o, 0);
    check_ticks(p, req);
  endtask

  task automatic t_hold(input int p);
    send_synch(50);
    @(negedge clk);
    check(baud_valid_o == 1'b1, "R8", "valid kept during line activity", baud_valid_o, 1);
    check_ticks(p, "R8");
  endtask

  task automatic t_arm_clears();
    int n;
    @(posedge clk); #1 arm_i = 1'b1;
    @(posedge clk); #1 arm_i = 1'b0;
    @(negedge clk);
    check(!baud_valid_o && !synch_err_o, "R2", "flags after arm",
          {baud_valid_o, synch_err_o}, 0);
    count_ticks(60, n);
    check(n == 0, "R5", "ticks after arm", n, 0);
  endtask

  task automatic t_too_fast();
    int n;
    arm_pulse();
    send_synch(20);
    @(negedge clk);
    check(synch_err_o == 1'b1, "R6", "error for short period", synch_err_o, 1);
    check(baud_valid_o == 1'b0, "R6", "valid for short period", baud_valid_o, 0);
    count_ticks(60, n);
    check(n == 0, "R6", "ticks after short period", n, 0);
  endtask

  task automatic t_timeout();
    arm_pulse();
    line_i = 1'b0;
    repeat (4000) @(negedge clk);
    check(synch_err_o == 1'b0, "R7", "error before timeout", synch_err_o, 0);
    repeat (200) @(negedge clk);
    check(synch_err_o == 1'b1, "R7", "error after timeout", synch_err_o, 1);
    check(baud_valid_o == 1'b0, "R7", "valid after timeout", baud_valid_o, 0);
    #1 line_i = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_unarmed();
    t_measure(32, "R4");
    t_measure(37, "R10");
    t_hold(37);
    t_arm_clears();
    t_too_fast();
    t_timeout();
    t_measure(100, "R4");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule